// File: doc/BRIEF.md
# Multi-Rate Serial Time-Slot Switch

This block connects any one of 256 byte-wide input channels to any of 256 output time slots. The channels arrive on serial time-division-multiplexed lines, one bit per cell, most significant bit first. Each incoming byte is collected per lane and stored in a data store addressed by channel number. For every output slot, a connection table names the source channel. The byte is then read back and shifted out on the matching output lane.

The lines run at 2, 4 or 8 Mb/s. A mode word either applies one common rate to both sides or, when its mixed-rate flag is set, gives the input and output sides rates of their own, so the switch converts rate while it switches. The number of active lanes on each side follows from that side's rate, and the 256-channel total is always kept.

Every output slot picks constant delay or variable delay:
- Constant delay returns the byte from exactly one frame earlier. It is read from the half of a two-bank store that is not being written.
- Variable delay returns the newest byte received on that channel.

Timing:
- The block runs on one clock that equals the 8 Mb/s bit rate. A frame is 1024 clocks long.
- A 4 Mb/s cell spans 2 clocks and a 2 Mb/s cell spans 4 clocks.
- A frame-sync pulse restarts the frame.

Top module: `tdm_rate_switch`

## Requirements
- R1: When `frame_sync` is high on a clock edge, the next cycle is frame position 0; otherwise the position counts 0..1023 and wraps. A cell of length D clocks (D = 4, 2, 1 for 2, 4, 8 Mb/s) begins at positions that are multiples of D. Input bits are sampled on the first clock of each cell, MSB first. Each output bit appears one clock after its cell begins and holds for D clocks, MSB first. Slot `k` starts at position `k*8*D`.
- R2: At a uniform 2 Mb/s rate, 8 input and 8 output lanes are active, with 32 slots per lane.
- R3: At a uniform 4 Mb/s rate, lanes 0..3 are active on each side, with 64 slots per lane.
- R4: At a uniform 8 Mb/s rate, lanes 0 and 1 are active on each side, with 128 slots per lane.
- R5: Mode word (written with `cfg_mode_sel`=1):
  - bits [1:0] hold the uniform rate, bit [2] holds the mixed flag, bits [4:3] the input rate and bits [6:5] the output rate.
  - Rate codes are 0 = 2 Mb/s, 1 = 4 Mb/s, 2 = 8 Mb/s, and 3 behaves as 2 Mb/s.
  - With the flag set, bits [1:0] are ignored. With it clear, bits [6:3] are ignored.
- R6: In mixed mode, each side independently uses the lane count of its own rate (8, 4 or 2 lanes). Conversions 2→4, 2→8, 4→2 and 8→2 Mb/s all reach all 256 channels.
- R7: A constant-delay output slot carries the byte its source channel received in the previous frame.
- R8: A variable-delay output slot carries the source byte of the current frame if that byte's last bit was sampled before the slot's first cell began. Otherwise it carries the byte from the previous frame.
- R9: Inactive output lanes drive 0, and inactive input lanes have no effect on any output.
- R10: `need_fast_clk` is high exactly when the rate in effect on either side is 8 Mb/s.
- R11: After reset, all outputs are 0 and the mode is uniform 2 Mb/s.
- R12: Channel number = lane × slots-per-lane + slot. A connection write (`cfg_mode_sel`=0) stores `cfg_wdata`[7:0] as the source channel and `cfg_wdata`[8] as the constant-delay flag (1 = constant) for output channel `cfg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one 8 Mb/s bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | Frame restart pulse |
| ser_in | input | 8 | Serial input lanes |
| ser_out | output | 8 | Serial output lanes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode_sel | input | 1 | 1 = write mode word, 0 = write connection entry |
| cfg_addr | input | 8 | Output channel of a connection write |
| cfg_wdata | input | 9 | Connection entry or mode word |
| need_fast_clk | output | 1 | High when an 8 Mb/s side is in use |

## Verification
A byte store and a byte fetch can land in the same cycle. The store happens when an input channel's last bit is sampled. The fetch happens when an output slot whose variable-delay source is that channel begins loading. Mixed-rate modes with permuted connection tables make input slot ends fall right before, on, and after output slot starts on many channels. For each variable-delay slot, the bench compares the slot's first cell against the cycle of the source's last bit, predicts the current or the previous frame's byte, and compares the whole captured output byte.

// File: rtl/tdm_sw_pkg.sv
// Shared constants, the connection entry type and the rate decode.
// Assumes the largest clock divider (2 Mb/s cell) is 1 << LD_MAXDIV clocks.
package tdm_sw_pkg;
    localparam int NLANE      = 8;
    localparam int NCH        = 256;
    localparam int CH_W       = $clog2(NCH);
    localparam int LD_MAXDIV  = 2;

    typedef struct packed {
        logic            hold_frame;   // 1 = constant delay
        logic [CH_W-1:0] src;
    } conn_t;

    // Rate code to cell shift: 0 -> 2 Mb/s, 1 -> 4 Mb/s, 2 -> 8 Mb/s, 3 -> 2 Mb/s
    function automatic logic [1:0] rate_shift(input logic [1:0] code);
        return (code == 2'd3) ? 2'd0 : code;
    endfunction
endpackage

// File: rtl/tdm_frame_timer.sv
// Frame position counter and store bank select.
// Restarts on frame_sync, otherwise wraps after FRAME_LEN clocks; the bank
// flips at every frame start so the previous frame stays readable.
module tdm_frame_timer #(
    parameter  int FRAME_LEN = 1024,
    localparam int CNTW      = $clog2(FRAME_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_sync,
    output logic [CNTW-1:0] pos,
    output logic            wr_bank
);
    // Advance the frame position and flip the bank at each frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos     <= '0;
            wr_bank <= 1'b0;
        end else if (frame_sync || pos == CNTW'(FRAME_LEN - 1)) begin
            pos     <= '0;
            wr_bank <= ~wr_bank;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    // R1
    sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (pos == '0));

    // R7
    bank_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != '0) |-> $stable(wr_bank));
endmodule

// File: rtl/tdm_rx_lane.sv
// One serial input lane: samples the first clock of each cell, MSB first,
// and presents a finished byte with its slot for one clock.
// Assumes pos is the shared frame position; inactive lanes never strobe.
module tdm_rx_lane #(
    parameter int CNTW      = 10,
    parameter int LD_MAXDIV = 2,
    parameter int SLOTW     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNTW-1:0]  pos,
    input  logic [1:0]       rate_sh,
    input  logic             active,
    input  logic             ser_bit,
    output logic             byte_done,
    output logic [7:0]       byte_val,
    output logic [SLOTW-1:0] slot
);
    int         ld_div;
    logic       cell_start;
    logic [2:0] bit_idx;
    logic [6:0] shreg;

    // Decode cell start, bit number and slot from the frame position
    always_comb begin
        ld_div     = LD_MAXDIV - int'(rate_sh);
        cell_start = (pos & CNTW'((1 << ld_div) - 1)) == '0;
        bit_idx    = 3'(pos >> ld_div);
        slot       = SLOTW'(pos >> (ld_div + 3));
        byte_done  = active && cell_start && (bit_idx == 3'd7);
        byte_val   = {shreg, ser_bit};
    end

    // Collect incoming bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (active && cell_start)
            shreg <= {shreg[5:0], ser_bit};
    end
endmodule

// File: rtl/tdm_tx_lane.sv
// One serial output lane: loads a byte at the first cell of each slot and
// shifts it out MSB first, one registered bit per cell; idle lanes drive 0.
module tdm_tx_lane #(
    parameter int CNTW      = 10,
    parameter int LD_MAXDIV = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CNTW-1:0] pos,
    input  logic [1:0]      rate_sh,
    input  logic            active,
    input  logic [7:0]      load_byte,
    output logic            ser_bit
);
    int         ld_div;
    logic       cell_start;
    logic [2:0] bit_idx;
    logic [6:0] shreg;

    // Decode cell start and bit number from the frame position
    always_comb begin
        ld_div     = LD_MAXDIV - int'(rate_sh);
        cell_start = (pos & CNTW'((1 << ld_div) - 1)) == '0;
        bit_idx    = 3'(pos >> ld_div);
    end

    // Load at slot start, otherwise shift at each cell start
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            shreg   <= '0;
            ser_bit <= 1'b0;
        end else if (cell_start) begin
            if (bit_idx == 3'd0) begin
                ser_bit <= load_byte[7];
                shreg   <= load_byte[6:0];
            end else begin
                ser_bit <= shreg[6];
                shreg   <= {shreg[5:0], 1'b0};
            end
        end
    end

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (ser_bit == 1'b0));

    // R1
    msb_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cell_start && bit_idx == 3'd0) |=> (ser_bit == $past(load_byte[7])));
endmodule

// File: rtl/tdm_data_store.sv
// Channel byte store: a live copy for variable delay and two frame banks for
// constant delay. Every active lane may write in the same clock; reads are
// combinational, so a write becomes visible in the following cycle.
module tdm_data_store #(
    parameter int NLANE = 8,
    parameter int NCH   = 256,
    parameter int CH_W  = 8
) (
    input  logic                        clk,
    input  logic                        wr_bank,
    input  logic [NLANE-1:0]            we,
    input  logic [NLANE-1:0][CH_W-1:0]  waddr,
    input  logic [NLANE-1:0][7:0]       wdata,
    input  logic [NLANE-1:0][CH_W-1:0]  raddr,
    input  logic [NLANE-1:0]            rhold,
    output logic [NLANE-1:0][7:0]       rdata
);
    logic [7:0] live_m [NCH];
    logic [7:0] bank_m [2][NCH];
    logic       rd_bank;

    // Store each finished byte in the live copy and the current bank
    always_ff @(posedge clk) begin
        for (int i = 0; i < NLANE; i++) begin
            if (we[i]) begin
                live_m[waddr[i]]          <= wdata[i];
                bank_m[wr_bank][waddr[i]] <= wdata[i];
            end
        end
    end

    // Fetch from the previous-frame bank or from the live copy
    always_comb begin
        rd_bank = ~wr_bank;
        for (int i = 0; i < NLANE; i++)
            rdata[i] = rhold[i] ? bank_m[rd_bank][raddr[i]] : live_m[raddr[i]];
    end
endmodule

// File: rtl/tdm_rate_switch.sv
// Multi-rate serial time-slot switch top. Decodes the mode word into per-side
// rates and lane counts, maps lane/slot to channel numbers, and routes bytes
// through the connection table. Assumes one clock per 8 Mb/s bit.
module tdm_rate_switch
    import tdm_sw_pkg::*;
#(
    parameter  int NLANE_P    = tdm_sw_pkg::NLANE,
    parameter  int NCH_P      = tdm_sw_pkg::NCH,
    parameter  int LD_MAXDIV_P = tdm_sw_pkg::LD_MAXDIV,
    localparam int CW         = $clog2(NCH_P),
    localparam int LD_CPS_MIN = $clog2(NCH_P / NLANE_P),
    localparam int FRAME_LEN  = (NCH_P / NLANE_P) * 8 * (1 << LD_MAXDIV_P),
    localparam int CNTW       = $clog2(FRAME_LEN),
    localparam int SLOTW      = LD_CPS_MIN + LD_MAXDIV_P,
    localparam int LCW        = $clog2(NLANE_P) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_sync,
    input  logic [NLANE_P-1:0] ser_in,
    output logic [NLANE_P-1:0] ser_out,
    input  logic               cfg_we,
    input  logic               cfg_mode_sel,
    input  logic [CW-1:0]      cfg_addr,
    input  logic [CW:0]        cfg_wdata,
    output logic               need_fast_clk
);
    logic [6:0]                 mode_q;
    conn_t                      conn_m [NCH_P];
    logic [CNTW-1:0]            pos;
    logic                       wr_bank;
    logic [1:0]                 in_sh, out_sh;
    logic [LCW-1:0]             in_lanes, out_lanes;
    logic [SLOTW-1:0]           out_slot;
    logic [NLANE_P-1:0]         rx_done, in_act, out_act, rd_hold;
    logic [NLANE_P-1:0][7:0]    rx_byte, rd_data;
    logic [NLANE_P-1:0][SLOTW-1:0] rx_slot;
    logic [NLANE_P-1:0][CW-1:0] wr_addr, rd_addr;

    // Hold the mode word
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (cfg_we && cfg_mode_sel)
            mode_q <= cfg_wdata[6:0];
    end

    // Connection table writes
    always_ff @(posedge clk) begin
        if (cfg_we && !cfg_mode_sel)
            conn_m[cfg_addr] <= conn_t'(cfg_wdata);
    end

    // Per-side rate, lane count and output slot number
    always_comb begin
        in_sh         = mode_q[2] ? rate_shift(mode_q[4:3]) : rate_shift(mode_q[1:0]);
        out_sh        = mode_q[2] ? rate_shift(mode_q[6:5]) : rate_shift(mode_q[1:0]);
        in_lanes      = LCW'(NLANE_P >> in_sh);
        out_lanes     = LCW'(NLANE_P >> out_sh);
        need_fast_clk = (int'(in_sh) == LD_MAXDIV_P) || (int'(out_sh) == LD_MAXDIV_P);
        out_slot      = SLOTW'(pos >> (LD_MAXDIV_P - int'(out_sh) + 3));
    end

    tdm_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .pos(pos), .wr_bank(wr_bank)
    );

    for (genvar i = 0; i < NLANE_P; i++) begin : g_lane
        assign in_act[i]  = LCW'(i) < in_lanes;
        assign out_act[i] = LCW'(i) < out_lanes;
        assign wr_addr[i] = CW'((i << (LD_CPS_MIN + int'(in_sh))) + int'(rx_slot[i]));
        assign rd_addr[i] = conn_m[CW'((i << (LD_CPS_MIN + int'(out_sh))) + int'(out_slot))].src;
        assign rd_hold[i] = conn_m[CW'((i << (LD_CPS_MIN + int'(out_sh))) + int'(out_slot))].hold_frame;

        tdm_rx_lane #(.CNTW(CNTW), .LD_MAXDIV(LD_MAXDIV_P), .SLOTW(SLOTW)) u_rx (
            .clk(clk), .rst_n(rst_n), .pos(pos), .rate_sh(in_sh), .active(in_act[i]),
            .ser_bit(ser_in[i]), .byte_done(rx_done[i]), .byte_val(rx_byte[i]),
            .slot(rx_slot[i])
        );

        tdm_tx_lane #(.CNTW(CNTW), .LD_MAXDIV(LD_MAXDIV_P)) u_tx (
            .clk(clk), .rst_n(rst_n), .pos(pos), .rate_sh(out_sh), .active(out_act[i]),
            .load_byte(rd_data[i]), .ser_bit(ser_out[i])
        );
    end

    tdm_data_store #(.NLANE(NLANE_P), .NCH(NCH_P), .CH_W(CW)) u_store (
        .clk(clk), .wr_bank(wr_bank), .we(rx_done), .waddr(wr_addr), .wdata(rx_byte),
        .raddr(rd_addr), .rhold(rd_hold), .rdata(rd_data)
    );

    // R6
    lane_write_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rx_done) <= int'(in_lanes));

    // R10
    fast_clk_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_lanes == LCW'(2) || out_lanes == LCW'(2)) |-> need_fast_clk);
endmodule

// File: tb/tdm_rate_switch_test.sv
`timescale 1ns/1ps
module tdm_rate_switch_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic [7:0] ser_in = '0;
    logic [7:0] ser_out;
    logic       cfg_we = 1'b0;
    logic       cfg_mode_sel = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [8:0] cfg_wdata = '0;
    logic       need_fast_clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int         conn_src [256];
    bit         conn_hold[256];
    logic [7:0] cap [0:3][0:7][0:127];
    int         ish, osh, seed;

    tdm_rate_switch uut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ser_in(ser_in),
        .ser_out(ser_out), .cfg_we(cfg_we), .cfg_mode_sel(cfg_mode_sel),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .need_fast_clk(need_fast_clk)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] in_byte(input int f, input int s, input int sl);
        return 8'(((f * 53 + s * 31 + sl * 11 + seed * 7 + 5) ^ (sl >> 1)) & 255);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R12: connection entry = {hold, src}
    task automatic load_conn(input int mul, input int add, input int hold_mode);
        for (int oc = 0; oc < 256; oc++) begin
            conn_src[oc]  = (oc * mul + add) & 255;
            conn_hold[oc] = (hold_mode == 2) ? bit'(((oc >> 0) ^ (oc >> 3)) & 1) : bit'(hold_mode);
            @(negedge clk);
            cfg_we = 1'b1; cfg_mode_sel = 1'b0;
            cfg_addr = 8'(oc); cfg_wdata = {conn_hold[oc], 8'(conn_src[oc])};
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R5: mode word {out[6:5], in[4:3], mixed[2], uniform[1:0]}
    task automatic write_mode(input int uni, input bit mixed, input int inr, input int outr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode_sel = 1'b1; cfg_addr = '0;
        cfg_wdata = {2'b00, 2'(outr), 2'(inr), mixed, 2'(uni)};
        @(negedge clk);
        cfg_we = 1'b0; cfg_mode_sel = 1'b0;
    endtask

    task automatic drive_inputs(input int f, input int c);
        int dl, b, sl;
        dl = 2 - ish; b = (c >> dl) & 7; sl = c >> (dl + 3);
        for (int s = 0; s < 8; s++) begin
            if (s < (8 >> ish)) ser_in[s] = in_byte(f, s, sl)[7 - b];
            else                ser_in[s] = ((c * 7 + s) % 3) == 0;   // junk on idle lanes
        end
    endtask

    task automatic capture(input int g);
        int f, c, dl, b, sl;
        f = g / 1024; c = g % 1024; dl = 2 - osh;
        if ((c & ((1 << dl) - 1)) == 0) begin
            b = (c >> dl) & 7; sl = c >> (dl + 3);
            for (int o = 0; o < 8; o++) cap[f][o][sl][7 - b] = ser_out[o];
        end
    endtask

    // Prime with a frame pulse at an arbitrary position, then run nf frames (R1)
    task automatic run_frames(input int nf);
        @(negedge clk);
        frame_sync = 1'b1; ser_in = 8'hA5;
        for (int g = 0; g <= nf * 1024; g++) begin
            @(negedge clk);
            if (g >= 1) capture(g - 1);
            frame_sync = ((g % 1024) == 1023) && (g < nf * 1024);
            if (g < nf * 1024) drive_inputs(g / 1024, g % 1024);
            else ser_in = '0;
        end
        frame_sync = 1'b0;
    endtask

    task automatic compare(input int nf, input string mode_req);
        int cpso, cpsi, di, dob, oc, src, si, ss, cw, cl;
        logic [7:0] exp;
        string dreq;
        cpso = 32 << osh; cpsi = 32 << ish; di = 4 >> ish; dob = 4 >> osh;
        for (int f = 1; f < nf; f++) begin
            for (int o = 0; o < 8; o++) begin
                for (int sl = 0; sl < cpso; sl++) begin
                    if (o >= (8 >> osh)) begin
                        exp = 8'h00; dreq = "R9";
                    end else begin
                        oc = o * cpso + sl; src = conn_src[oc];
                        si = src / cpsi; ss = src % cpsi;
                        if (conn_hold[oc]) begin
                            exp = in_byte(f - 1, si, ss); dreq = "R7";
                        end else begin
                            cw = ss * 8 * di + 7 * di; cl = sl * 8 * dob;
                            exp = (cw < cl) ? in_byte(f, si, ss) : in_byte(f - 1, si, ss);
                            dreq = "R8";
                        end
                    end
                    check(cap[f][o][sl] === exp, {mode_req, " ", dreq, " R12"},
                          $sformatf("frame %0d lane %0d slot %0d", f, o, sl),
                          int'(cap[f][o][sl]), int'(exp));
                end
            end
        end
    endtask

    task automatic run_case(input int is, input int os, input bit fast,
                            input string req, input int sd);
        ish = is; osh = os; seed = sd;
        check(need_fast_clk === fast, "R10", {req, " fast clock flag"}, int'(need_fast_clk), int'(fast));
        run_frames(3);
        compare(3, req);
    endtask

    // R11: reset state and default uniform 2 Mb/s mode
    task automatic scen_reset_default();
        do_reset();
        check(ser_out === 8'h00, "R11", "serial outputs after reset", int'(ser_out), 0);
        check(need_fast_clk === 1'b0, "R11", "fast flag after reset", int'(need_fast_clk), 0);
        load_conn(97, 13, 2);
        run_case(0, 0, 1'b0, "R2 R11", 1);
    endtask

    // R3 with junk in/out fields ignored (R5)
    task automatic scen_uniform_4m();
        do_reset();
        write_mode(1, 1'b0, 2, 2);
        load_conn(45, 200, 0);
        run_case(1, 1, 1'b0, "R3 R5", 2);
    endtask

    task automatic scen_uniform_8m();
        do_reset();
        write_mode(2, 1'b0, 0, 0);
        load_conn(171, 7, 1);
        run_case(2, 2, 1'b1, "R4", 3);
    endtask

    // R6 2->4 with an 8 Mb/s uniform field that must be ignored (R5)
    task automatic scen_mixed_2_to_4();
        do_reset();
        write_mode(2, 1'b1, 0, 1);
        load_conn(59, 91, 2);
        run_case(0, 1, 1'b0, "R6 R5", 4);
    endtask

    task automatic scen_mixed_2_to_8();
        do_reset();
        write_mode(3, 1'b1, 0, 2);
        load_conn(13, 130, 0);
        run_case(0, 2, 1'b1, "R6", 5);
    endtask

    task automatic scen_mixed_4_to_2();
        do_reset();
        write_mode(0, 1'b1, 1, 3);
        load_conn(201, 3, 2);
        run_case(1, 0, 1'b0, "R6", 6);
    endtask

    task automatic scen_mixed_8_to_2();
        do_reset();
        write_mode(1, 1'b1, 2, 0);
        load_conn(77, 250, 0);
        run_case(2, 0, 1'b1, "R6", 7);
    endtask

    initial begin
        scen_reset_default();
        scen_uniform_4m();
        scen_uniform_8m();
        scen_mixed_2_to_4();
        scen_mixed_2_to_8();
        scen_mixed_4_to_2();
        scen_mixed_8_to_2();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule